// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of a three-wire serial EEPROM as seen from its pins. It has a chip select, a shift clock, a serial data input, a serial data output with an output enable, and a static strap that picks the word width. Each instruction is framed by chip select and clocked in one bit per rising shift-clock edge. The block decodes a start bit, a two-bit opcode and an address, then reads, writes or erases one word, erases or writes the whole array, or sets or clears the latch that permits programming. The storage is 1 Kbit of on-chip RAM. Its contents survive a reset.

All pins are sampled in the system clock domain through two-stage synchronisers. A programming instruction starts a self-timed cycle that lasts a set number of system clocks. While that cycle runs, the host can poll completion on the data output.

Top module: `mwire_eeprom`

## Requirements
- R1: An instruction begins at the first 1 seen on data in while chip select is high; 0 bits before it are ignored. The two bits after it are the opcode: 10 read, 01 write, 11 erase, 00 special group. The address follows, most significant bit first. It is A16_BITS bits long (6 by default) with the strap high and one bit longer with the strap low, and every bit is clocked in, including those of the special group.
- R2: In the special group, the two most significant address bits select the operation: 11 sets the programming latch, 00 clears it, 10 erases the whole array and 01 writes the whole array with the data word that follows.
- R3: For a read, once the last address bit is taken, data out is enabled and shows one 0 bit. Each following rising shift-clock edge then presents the next bit of the addressed word, most significant bit first. Data out settles within 3 system clocks of the synchronised edge.
- R4: With the strap high, words are 16 bits wide. With it low, words are 8 bits wide and byte address b maps to 16-bit word b>>1: even b is bits [15:8] and odd b is bits [7:0].
- R5: The programming latch is clear after reset. While it is clear, write, erase, erase-all and write-all change no stored bit and produce no busy status.
- R6: A write replaces the addressed word with the data clocked in after the address, with no erase needed first. An erase sets the addressed word to all ones. In 8-bit mode only that byte changes.
- R7: Erase-all sets every bit to 1. Write-all stores the data word in every word, and in 8-bit mode the byte fills both halves of every 16-bit word.
- R8: After a programming instruction is accepted, lowering and then raising chip select enables data out with status: 0 while the cycle runs, 1 once it has ended. The cycle lasts PROG_CYCLES system clocks from the synchronised last bit. Status ends at the next start bit or when chip select falls. Shift-clock edges are ignored while the cycle runs.
- R9: The output enable is low after reset, and it goes low within 3 system clocks of chip select going low.
- R10: Lowering chip select before the last bit of an instruction abandons it: memory and the latch are unchanged, and no status follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock, sampled on rising edges |
| di_i | input | 1 | Serial data input |
| org16_i | input | 1 | Organisation strap: 1 for 16-bit words, 0 for 8-bit words |
| do_o | output | 1 | Serial data output (read data or ready/busy status) |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
Each pin passes through two synchroniser stages, and the controller acts one clock after it sees an edge. A read bit or a status change is therefore due three system clocks after the bench moves the pin. The bench changes inputs on falling system-clock edges, keeps the shift clock high and low for four system clocks each, and samples data out eight clocks after each rising shift-clock edge, so each result is long settled when it is sampled. The self-timed cycle starts about three clocks after the last rising edge, so the first status poll, taken about twenty clocks later, must read busy. Ready must then arrive between PROG_CYCLES-30 and PROG_CYCLES polling clocks later.

// File: rtl/mwire_pkg.sv
package mwire_pkg;
  typedef enum logic [1:0] {
    OPC_SPECIAL = 2'b00,
    OPC_WRITE   = 2'b01,
    OPC_READ    = 2'b10,
    OPC_ERASE   = 2'b11
  } mw_opc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_SKIP,
    ST_BUSY
  } mw_state_e;

  localparam logic [1:0] SP_DISABLE = 2'b00;
  localparam logic [1:0] SP_WRALL   = 2'b01;
  localparam logic [1:0] SP_ERALL   = 2'b10;
  localparam logic [1:0] SP_ENABLE  = 2'b11;
endpackage

// File: rtl/mwire_sync.sv
module mwire_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mwire_store.sv
module mwire_store #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [1:0]    be,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DW / 2;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < 2; l++)
        if (be[l]) mem[waddr][l*HALF +: HALF] <= wdata[l*HALF +: HALF];
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mwire_ctrl.sv
module mwire_ctrl
  import mwire_pkg::*;
#(
  parameter int A16_BITS    = 6,
  parameter int PROG_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_s,
  input  logic                sk_s,
  input  logic                di_s,
  input  logic                org16,
  output logic                mem_we,
  output logic [1:0]          mem_be,
  output logic [A16_BITS-1:0] mem_waddr,
  output logic [15:0]         mem_wdata,
  output logic [A16_BITS-1:0] mem_raddr,
  input  logic [15:0]         mem_rdata,
  output logic                dout,
  output logic                dout_oe
);
  localparam int A8_BITS = A16_BITS + 1;
  localparam int WORDS   = 1 << A16_BITS;
  localparam int PC_W    = $clog2(PROG_CYCLES + 1);
  localparam int BC_W    = 5;

  mw_state_e           st;
  mw_opc_e             opc;
  logic                sk_d, cs_d;
  logic [BC_W-1:0]     bcnt;
  logic [14:0]         shin;
  logic                wen, busy, arm, show, rd_oe, rd_lane, rd_org;
  logic [1:0]          rd_pend;
  logic [15:0]         shout;
  logic                pg_all, pg_org;
  logic [15:0]         pg_data;
  logic [A8_BITS-1:0]  pg_addr;
  logic [PC_W-1:0]     pcnt;

  logic                sk_rise, cs_rise, step;
  logic [BC_W-1:0]     last_abit, last_dbit;
  logic [A8_BITS-1:0]  addr_now;
  logic [15:0]         data_now;
  logic [1:0]          top2;
  logic                addr_done, data_done, erase_go, data_go;

  always_comb begin
    sk_rise   = sk_s & ~sk_d;
    cs_rise   = cs_s & ~cs_d;
    step      = cs_s & sk_rise & (st != ST_BUSY);
    last_abit = org16 ? BC_W'(A16_BITS - 1) : BC_W'(A8_BITS - 1);
    last_dbit = org16 ? BC_W'(15) : BC_W'(7);
    addr_now  = {shin[A8_BITS-2:0], di_s};
    data_now  = {shin, di_s};
    top2      = org16 ? addr_now[A16_BITS-1 -: 2] : addr_now[A8_BITS-1 -: 2];
    addr_done = step && (st == ST_ADDR) && (bcnt == last_abit);
    data_done = step && (st == ST_DATA) && (bcnt == last_dbit);
    erase_go  = addr_done && wen &&
                ((opc == OPC_ERASE) || (opc == OPC_SPECIAL && top2 == SP_ERALL));
    data_go   = data_done && wen;
  end

  // memory write port, driven during the self-timed cycle
  always_comb begin
    mem_we    = busy && (pg_all ? (int'(pcnt) < WORDS) : (pcnt == '0));
    mem_waddr = pg_all ? pcnt[A16_BITS-1:0]
              : (pg_org ? pg_addr[A16_BITS-1:0] : pg_addr[A8_BITS-1:1]);
    mem_be    = (pg_all || pg_org) ? 2'b11 : (pg_addr[0] ? 2'b01 : 2'b10);
    mem_wdata = pg_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; opc <= OPC_SPECIAL; sk_d <= 1'b0; cs_d <= 1'b0;
      bcnt <= '0; shin <= '0; wen <= 1'b0; busy <= 1'b0; arm <= 1'b0;
      show <= 1'b0; rd_oe <= 1'b0; rd_lane <= 1'b0; rd_org <= 1'b0;
      rd_pend <= '0; shout <= '0; pg_all <= 1'b0; pg_org <= 1'b0;
      pg_data <= '0; pg_addr <= '0; pcnt <= '0; mem_raddr <= '0;
      dout <= 1'b0; dout_oe <= 1'b0;
    end else begin
      sk_d    <= sk_s;
      cs_d    <= cs_s;
      rd_pend <= {rd_pend[0], 1'b0};
      dout_oe <= cs_s & (rd_oe | show);
      if (rd_pend[1])
        shout <= rd_org ? mem_rdata
                        : {(rd_lane ? mem_rdata[7:0] : mem_rdata[15:8]), 8'h00};
      if (show) dout <= ~busy;
      if (busy) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == PC_W'(PROG_CYCLES - 1)) begin
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
      end
      if (!cs_s) begin
        show  <= 1'b0;
        rd_oe <= 1'b0;
        if (st != ST_BUSY) st <= ST_IDLE;
      end else begin
        if (cs_rise && arm) show <= 1'b1;
        if (step) begin
          unique case (st)
            ST_IDLE: if (di_s) begin
              st <= ST_OPC; bcnt <= '0; arm <= 1'b0; show <= 1'b0;
            end
            ST_OPC: begin
              opc  <= mw_opc_e'({opc[0], di_s});
              bcnt <= bcnt + 1'b1;
              if (bcnt == BC_W'(1)) begin st <= ST_ADDR; bcnt <= '0; end
            end
            ST_ADDR: begin
              shin <= data_now[14:0];
              bcnt <= bcnt + 1'b1;
              if (addr_done) begin
                bcnt    <= '0;
                pg_all  <= (opc == OPC_SPECIAL);
                pg_addr <= org16 ? {1'b0, addr_now[A16_BITS-1:0]} : addr_now;
                st      <= ST_SKIP;
                unique case (opc)
                  OPC_READ: begin
                    mem_raddr <= org16 ? addr_now[A16_BITS-1:0] : addr_now[A8_BITS-1:1];
                    rd_lane   <= addr_now[0];
                    rd_org    <= org16;
                    rd_pend   <= 2'b01;
                    rd_oe     <= 1'b1;
                    dout      <= 1'b0;
                    st        <= ST_READ;
                  end
                  OPC_WRITE: st <= ST_DATA;
                  OPC_ERASE: ;
                  OPC_SPECIAL: begin
                    if (top2 == SP_ENABLE)  wen <= 1'b1;
                    if (top2 == SP_DISABLE) wen <= 1'b0;
                    if (top2 == SP_WRALL)   st  <= ST_DATA;
                  end
                endcase
              end
            end
            ST_DATA: begin
              shin <= data_now[14:0];
              bcnt <= bcnt + 1'b1;
              if (data_done) st <= ST_SKIP;
            end
            ST_READ: begin
              dout  <= shout[15];
              shout <= {shout[14:0], 1'b0};
            end
            default: ;
          endcase
          if (erase_go || data_go) begin
            st      <= ST_BUSY;
            busy    <= 1'b1;
            pcnt    <= '0;
            arm     <= 1'b1;
            pg_org  <= org16;
            pg_data <= erase_go ? 16'hFFFF
                     : (org16 ? data_now : {data_now[7:0], data_now[7:0]});
          end
        end
      end
    end
  end

  // R5
  wen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wen);
  // R5
  wen_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wen);
  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !dout_oe);
  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(pcnt) == PC_W'(PROG_CYCLES - 1));
  // R8
  status_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(show) && $past(busy)) |-> !dout);
  // R3
  drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_oe, show}));
endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom #(
  parameter int A16_BITS    = 6,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org16_i,
  output logic do_o,
  output logic do_oe_o
);
  logic [2:0]          pins_s;
  logic                mem_we;
  logic [1:0]          mem_be;
  logic [A16_BITS-1:0] mem_waddr, mem_raddr;
  logic [15:0]         mem_wdata, mem_rdata;

  mwire_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_i, sk_i, di_i}),
    .q_o (pins_s)
  );

  mwire_ctrl #(.A16_BITS(A16_BITS), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (pins_s[2]),
    .sk_s      (pins_s[1]),
    .di_s      (pins_s[0]),
    .org16     (org16_i),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .dout      (do_o),
    .dout_oe   (do_oe_o)
  );

  mwire_store #(.AW(A16_BITS), .DW(16)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .be    (mem_be),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );
endmodule

// File: tb/mwire_eeprom_bench.sv
module mwire_eeprom_bench;
  localparam int A16  = 6;
  localparam int PROG = 100;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sk = 1'b0, din = 1'b0, org = 1'b1;
  logic dout, dout_oe;
  int vec = 0, bad = 0;
  logic [15:0] mdl [64];

  always #5 clk = ~clk;

  mwire_eeprom #(.A16_BITS(A16), .PROG_CYCLES(PROG)) u_mwire_eeprom (
    .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(din),
    .org16_i(org), .do_o(dout), .do_oe_o(dout_oe)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 1117) ^ 16'h9C21);
  endfunction
  function automatic int aw();
    return org ? A16 : A16 + 1;
  endfunction
  function automatic int dw();
    return org ? 16 : 8;
  endfunction
  function automatic int spec(logic [1:0] t);
    return int'(t) << (aw() - 2);
  endfunction
  function automatic logic [15:0] exp_of(int a);
    if (org) return mdl[a];
    return a[0] ? {8'h00, mdl[a>>1][7:0]} : {8'h00, mdl[a>>1][15:8]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clkn(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bit_out(logic b);
    din = b; clkn(4); sk = 1'b1; clkn(4); sk = 1'b0;
  endtask
  task automatic cs_on();
    cs = 1'b1; clkn(4);
  endtask
  task automatic cs_off();
    sk = 1'b0; din = 1'b0; cs = 1'b0; clkn(6);
  endtask
  task automatic hdr(logic [1:0] op, int addr, int lead);
    for (int i = 0; i < lead; i++) bit_out(1'b0);
    bit_out(1'b1); bit_out(op[1]); bit_out(op[0]);
    for (int i = aw() - 1; i >= 0; i--) bit_out(addr[i]);
  endtask
  task automatic cmd(logic [1:0] op, int addr, logic [15:0] data, bit has_data);
    cs_on();
    hdr(op, addr, 0);
    if (has_data) for (int i = dw() - 1; i >= 0; i--) bit_out(data[i]);
    cs_off();
  endtask
  task automatic wait_ready(string req, output int n);
    cs = 1'b1;
    n = 0;
    while (!(dout_oe === 1'b1 && dout === 1'b1) && n < PROG + 60) begin
      clkn(1); n++;
    end
    chk(req, {15'd0, dout_oe & dout}, 16'd1);
    cs_off();
  endtask
  task automatic prog(logic [1:0] op, int addr, logic [15:0] data, bit has_data);
    int n;
    cmd(op, addr, data, has_data);
    wait_ready("R8 ready", n);
  endtask
  task automatic no_status(string req);
    cs = 1'b1; clkn(8);
    chk(req, {15'd0, dout_oe}, 16'd0);
    cs_off();
  endtask
  task automatic rd(int addr, int lead, output logic [15:0] v);
    cs_on();
    hdr(2'b10, addr, lead);
    clkn(1);
    chk("R3 dummy bit", {14'd0, dout_oe, dout}, 16'b10);
    v = '0;
    for (int i = 0; i < dw(); i++) begin
      sk = 1'b1; clkn(4); sk = 1'b0; clkn(4);
      v = {v[14:0], dout};
    end
    cs_off();
  endtask
  task automatic rd_chk(string req, int addr);
    logic [15:0] v;
    rd(addr, 0, v);
    chk(req, v, exp_of(addr));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] v;
    clkn(6); rst = 1'b0; clkn(2);
    // R9 reset state
    chk("R9 oe after reset", {15'd0, dout_oe}, 16'd0);
    // R5 latch clear after reset: a write yields no busy status
    cmd(2'b01, 5, 16'h1111, 1);
    no_status("R5 no status with latch clear");
    // R2 enable, then write-all with timing check
    cmd(2'b00, spec(2'b11), 16'h0, 0);
    cmd(2'b00, spec(2'b01), 16'hA5C3, 1);
    for (int i = 0; i < 64; i++) mdl[i] = 16'hA5C3;
    cs = 1'b1; clkn(8);
    chk("R8 busy shows 0", {14'd0, dout_oe, dout}, 16'b10);
    wait_ready("R8 ready", n);
    chk("R8 cycle length", {15'd0, (n >= PROG - 30 && n <= PROG)}, 16'd1);
    rd_chk("R7 write-all word 0", 0);
    rd_chk("R7 write-all word 63", 63);
    // R2 disable clears the latch: write and erase-all ignored
    cmd(2'b00, spec(2'b00), 16'h0, 0);
    cmd(2'b01, 5, 16'h1111, 1);
    no_status("R5 write ignored");
    cmd(2'b00, spec(2'b10), 16'h0, 0);
    no_status("R5 erase-all ignored");
    rd_chk("R5 word 5 kept", 5);
    rd_chk("R5 word 7 kept", 7);
    // R10 abort mid-data
    cmd(2'b00, spec(2'b11), 16'h0, 0);
    cs_on();
    hdr(2'b01, 9, 0);
    for (int i = 0; i < 8; i++) bit_out(1'b0);
    cs_off();
    no_status("R10 abort gives no status");
    rd_chk("R10 abort leaves word", 9);
    // R6 sweep of writes over all words
    for (int a = 0; a < 64; a++) begin
      prog(2'b01, a, pat(a), 1);
      mdl[a] = pat(a);
    end
    // R1 leading zeros before the start bit are ignored
    rd(0, 2, v);
    chk("R1 leading zeros", v, mdl[0]);
    for (int a = 0; a < 64; a++) rd_chk("R6 word readback", a);
    // R6 erase one word
    prog(2'b11, 10, 16'h0, 0);
    mdl[10] = 16'hFFFF;
    rd_chk("R6 erase word", 10);
    // R4 8-bit view of every byte
    org = 1'b0;
    clkn(2);
    for (int b = 0; b < 128; b++) rd_chk("R4 byte readback", b);
    // R6 byte write and byte erase in 8-bit mode
    prog(2'b01, 3, 16'h007E, 1);
    mdl[1][7:0] = 8'h7E;
    prog(2'b11, 30, 16'h0, 0);
    mdl[15][15:8] = 8'hFF;
    rd_chk("R6 byte erase", 30);
    rd_chk("R6 byte erase neighbour", 31);
    org = 1'b1;
    clkn(2);
    rd_chk("R4 byte write in word", 1);
    rd_chk("R4 byte erase in word", 15);
    // R7 write-all of a byte in 8-bit mode
    org = 1'b0;
    clkn(2);
    prog(2'b00, spec(2'b01), 16'h003C, 1);
    for (int i = 0; i < 64; i++) mdl[i] = 16'h3C3C;
    org = 1'b1;
    clkn(2);
    rd_chk("R7 byte write-all", 0);
    rd_chk("R7 byte write-all", 33);
    // R2 erase-all
    prog(2'b00, spec(2'b10), 16'h0, 0);
    for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
    rd_chk("R7 erase-all", 12);
    rd_chk("R2 erase-all", 63);
    // R9 output enable drops with chip select
    cs_on();
    hdr(2'b10, 4, 0);
    cs = 1'b0; clkn(4);
    chk("R9 oe after cs low", {15'd0, dout_oe}, 16'd0);
    cs_off();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule